// File: doc/BRIEF.md
# Scatter-Gather Transmit Descriptor Walker

This block moves data from memory onto a byte-wide AXI4-Stream master by following a linked chain of descriptors. Each descriptor names a buffer and a byte count, and carries start-of-frame and end-of-frame flags. A frame may therefore be spread over several buffers. The block fetches a descriptor, marks it complete in memory, streams its buffer bytes in address order, and then follows the descriptor's next pointer.

A register block outside this one loads the first descriptor address and supplies a run level. It writes a tail pointer with a one-cycle kick. The walk stops after the descriptor at the tail address has been handled. It also stops at any descriptor that memory already marks complete. In both cases the idle flag is raised. The sideband words of each frame come from its start-of-frame descriptor and are held on TUSER. A pulse is sent to the interrupt logic each time an end-of-frame descriptor finishes. All memory traffic, including descriptor reads, status write-back and buffer reads, shares one word request/acknowledge port.

Top module: `sgw_tx_walker`

## Requirements
- R1: After reset, idle_o is 1, mem_req_o is 0, m_tvalid_o is 0 and cur_o is 0.
- R2: kick_i captures tail_i and clears idle. A descriptor walk starts only while run_i is 1 and idle is 0. While run_i is 0 no memory request is issued.
- R3: The descriptor layout uses byte offsets from its base. Offset 0 holds the next pointer (low word). Offset 8 holds the buffer address (low word). Offset 24 holds control and offset 28 holds status. Offsets 32 to 52 hold six sideband words. Control bits 22:0 are the byte length, bit 26 marks end of frame and bit 27 marks start of frame. Memory words are little-endian, so the byte at address A travels on bits 8*(A mod 4)+7 : 8*(A mod 4).
- R4: Each descriptor sends exactly its length in bytes, in ascending address order, starting at its buffer address. The descriptors of one frame follow each other with no gap and no repeated byte.
- R5: m_tlast_o is 1 only on the final byte of a descriptor whose end-of-frame flag is set.
- R6: m_tuser_o holds the six sideband words of the latest start-of-frame descriptor, with word j at bits 32*j+31 : 32*j, for every beat of that frame.
- R7: Every descriptor that moves data has its status word rewritten to its length OR 0x80000000.
- R8: A descriptor fetched with status bit 31 already set produces no write-back and no bytes. It raises idle and leaves cur_o pointing at that descriptor.
- R9: After each descriptor, cur_o takes that descriptor's next pointer. If the finished descriptor's address equals the tail, idle is raised and the walk stops.
- R10: frame_done_o pulses for one cycle per end-of-frame descriptor, two cycles after the handshake of its TLAST beat.
- R11: While m_tready_i is 0, m_tvalid_o, m_tdata_o and m_tlast_o hold, and no byte is lost or duplicated.
- R12: A memory request keeps mem_addr_o and mem_we_o stable until mem_ack_i.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| run_i | input | 1 | Run level from the register block |
| kick_i | input | 1 | Tail pointer write strobe |
| tail_i | input | ADDR_W | Tail descriptor address |
| cur_wr_i | input | 1 | Load current pointer (taken while waiting) |
| cur_i | input | ADDR_W | New current descriptor address |
| idle_o | output | 1 | Walk stopped |
| cur_o | output | ADDR_W | Current descriptor address |
| frame_done_o | output | 1 | End-of-frame completion pulse |
| mem_req_o | output | 1 | Memory request |
| mem_we_o | output | 1 | Request is a write |
| mem_addr_o | output | ADDR_W | Byte address, word aligned |
| mem_wdata_o | output | 32 | Write data |
| mem_ack_i | input | 1 | Request accepted; read data valid |
| mem_rdata_i | input | 32 | Read data |
| m_tvalid_o | output | 1 | Stream valid |
| m_tready_i | input | 1 | Stream ready |
| m_tdata_o | output | 8 | Stream byte |
| m_tlast_o | output | 1 | Final byte of frame |
| m_tuser_o | output | 192 | Frame sideband words |

## Verification
A wrong descriptor index or lane counter shows as a wrong byte value on the first beat that follows it. That happens within four beats of the fault. An error in the tail compare or in the pointer update shows up in idle_o or cur_o within a few cycles after the last beat. A lost completion shows up as a status word left unchanged in memory, found when the walk ends. A stuck sideband register shows up as a wrong TUSER on the next frame. Lengths from one to nine bytes, frames spread over three buffers, and random stalls on both the stream and the memory side push every lane and word boundary onto the ports.

// File: rtl/sgw_pkg.sv
package sgw_pkg;
  localparam int WORD_W     = 32;
  localparam int DESC_WORDS = 14;
  localparam int IDX_W      = $clog2(DESC_WORDS);
  localparam int LEN_W      = 23;
  localparam int N_APP      = 6;
  // word slots inside one descriptor
  localparam int SLOT_NEXT  = 0;
  localparam int SLOT_BUF   = 2;
  localparam int SLOT_CTRL  = 6;
  localparam int SLOT_STAT  = 7;
  localparam int SLOT_APP   = 8;
  // flag bit positions
  localparam int BIT_EOF    = 26;
  localparam int BIT_SOF    = 27;
  localparam int BIT_DONE   = 31;

  typedef enum logic [2:0] {
    S_WAIT, S_FETCH, S_EVAL, S_WB, S_DATA, S_NEXT
  } walk_st_t;

  typedef enum logic [1:0] {
    E_OFF, E_RD, E_OUT
  } emit_st_t;

  function automatic logic [LEN_W-1:0] ctrl_len(input logic [WORD_W-1:0] c);
    return c[LEN_W-1:0];
  endfunction

  function automatic logic [WORD_W-1:0] done_status(input logic [LEN_W-1:0] n);
    return WORD_W'(n) | (WORD_W'(1) << BIT_DONE);
  endfunction

  function automatic logic [7:0] lane_byte(input logic [WORD_W-1:0] w,
                                           input logic [1:0] lane);
    return w[8*lane +: 8];
  endfunction
endpackage

// File: rtl/sgw_desc_store.sv
module sgw_desc_store #(
  parameter int NW = 14,
  parameter int DW = 32,
  localparam int IW = $clog2(NW)
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            wr_i,
  input  logic [IW-1:0]   idx_i,
  input  logic [DW-1:0]   data_i,
  output logic [NW*DW-1:0] words_o
);
  for (genvar g = 0; g < NW; g++) begin : g_slot
    logic [DW-1:0] slot_q;
    always_ff @(posedge clk) begin
      if (!rst_n)                              slot_q <= '0;
      else if (wr_i && (idx_i == IW'(g)))      slot_q <= data_i;
    end
    assign words_o[g*DW +: DW] = slot_q;
  end
endmodule

// File: rtl/sgw_byte_emit.sv
module sgw_byte_emit
  import sgw_pkg::*;
#(
  parameter int ADDR_W = 32,
  localparam int BPW   = WORD_W / 8,
  localparam int LW    = $clog2(BPW)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start_i,
  input  logic [ADDR_W-1:0] base_i,
  input  logic [LEN_W-1:0]  len_i,
  input  logic              eof_i,
  output logic              rd_req_o,
  output logic [ADDR_W-1:0] rd_addr_o,
  input  logic              rd_ack_i,
  input  logic [WORD_W-1:0] rd_data_i,
  output logic              tvalid_o,
  input  logic              tready_i,
  output logic [7:0]        tdata_o,
  output logic              tlast_o,
  output logic              done_o
);
  emit_st_t          st_q;
  logic [LEN_W-1:0]  rem_q;
  logic [ADDR_W-1:0] addr_q;
  logic [WORD_W-1:0] word_q;
  logic [LW-1:0]     lane_q;
  logic              eof_q, done_q;

  wire beat     = (st_q == E_OUT) && tready_i;
  wire last_one = (rem_q == LEN_W'(1));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st_q <= E_OFF; rem_q <= '0; addr_q <= '0; word_q <= '0;
      lane_q <= '0; eof_q <= 1'b0; done_q <= 1'b0;
    end else begin
      done_q <= 1'b0;
      case (st_q)
        E_OFF: if (start_i) begin
          rem_q  <= len_i;
          addr_q <= base_i;
          lane_q <= '0;
          eof_q  <= eof_i;
          st_q   <= E_RD;
        end
        E_RD: if (rd_ack_i) begin
          word_q <= rd_data_i;
          addr_q <= addr_q + ADDR_W'(BPW);
          st_q   <= E_OUT;
        end
        E_OUT: if (beat) begin
          rem_q  <= rem_q - LEN_W'(1);
          lane_q <= lane_q + LW'(1);
          if (last_one) begin
            st_q   <= E_OFF;
            done_q <= 1'b1;
          end else if (lane_q == LW'(BPW-1)) begin
            st_q <= E_RD;
          end
        end
        default: st_q <= E_OFF;
      endcase
    end
  end

  assign rd_req_o  = (st_q == E_RD);
  assign rd_addr_o = addr_q;
  assign tvalid_o  = (st_q == E_OUT);
  assign tdata_o   = lane_byte(word_q, 2'(lane_q));
  assign tlast_o   = (st_q == E_OUT) && eof_q && last_one;
  assign done_o    = done_q;
endmodule

// File: rtl/sgw_tx_walker.sv
module sgw_tx_walker
  import sgw_pkg::*;
#(
  parameter int ADDR_W = 32,
  localparam int USER_W = N_APP * WORD_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              run_i,
  input  logic              kick_i,
  input  logic [ADDR_W-1:0] tail_i,
  input  logic              cur_wr_i,
  input  logic [ADDR_W-1:0] cur_i,
  output logic              idle_o,
  output logic [ADDR_W-1:0] cur_o,
  output logic              frame_done_o,
  output logic              mem_req_o,
  output logic              mem_we_o,
  output logic [ADDR_W-1:0] mem_addr_o,
  output logic [WORD_W-1:0] mem_wdata_o,
  input  logic              mem_ack_i,
  input  logic [WORD_W-1:0] mem_rdata_i,
  output logic              m_tvalid_o,
  input  logic              m_tready_i,
  output logic [7:0]        m_tdata_o,
  output logic              m_tlast_o,
  output logic [USER_W-1:0] m_tuser_o
);
  walk_st_t          st_q;
  logic [IDX_W-1:0]  k_q;
  logic [ADDR_W-1:0] cur_q, tail_q;
  logic              idle_q;
  logic [USER_W-1:0] user_q;
  logic [DESC_WORDS*WORD_W-1:0] words;

  // decoded descriptor fields
  wire [WORD_W-1:0] w_next = words[SLOT_NEXT*WORD_W +: WORD_W];
  wire [WORD_W-1:0] w_buf  = words[SLOT_BUF*WORD_W  +: WORD_W];
  wire [WORD_W-1:0] w_ctrl = words[SLOT_CTRL*WORD_W +: WORD_W];
  wire [WORD_W-1:0] w_stat = words[SLOT_STAT*WORD_W +: WORD_W];
  wire [USER_W-1:0] w_app  = words[SLOT_APP*WORD_W  +: USER_W];
  wire [LEN_W-1:0]  d_len  = ctrl_len(w_ctrl);
  wire d_sof  = w_ctrl[BIT_SOF];
  wire d_eof  = w_ctrl[BIT_EOF];
  wire d_done = w_stat[BIT_DONE];

  logic unused_desc_bits;
  assign unused_desc_bits = ^{words[SLOT_BUF*WORD_W-1:WORD_W],
                              words[SLOT_CTRL*WORD_W-1:(SLOT_BUF+1)*WORD_W],
                              w_ctrl[WORD_W-1:BIT_SOF+1], w_ctrl[BIT_EOF-1:LEN_W],
                              w_stat[BIT_DONE-1:0]};

  // named internal events
  wire walk_go       = (st_q == S_WAIT) && run_i && !idle_q;
  wire fetch_take    = (st_q == S_FETCH) && mem_ack_i;
  wire hit_done_desc = (st_q == S_EVAL) && d_done;
  wire wb_take       = (st_q == S_WB) && mem_ack_i;
  wire emit_start    = wb_take && (d_len != '0);
  wire at_tail       = (st_q == S_NEXT) && (cur_q == tail_q);
  wire emit_done;

  sgw_desc_store #(.NW(DESC_WORDS), .DW(WORD_W)) u_store (
    .clk(clk), .rst_n(rst_n), .wr_i(fetch_take), .idx_i(k_q),
    .data_i(mem_rdata_i), .words_o(words));

  logic              em_req;
  logic [ADDR_W-1:0] em_addr;

  sgw_byte_emit #(.ADDR_W(ADDR_W)) u_emit (
    .clk(clk), .rst_n(rst_n), .start_i(emit_start), .base_i(ADDR_W'(w_buf)),
    .len_i(d_len), .eof_i(d_eof),
    .rd_req_o(em_req), .rd_addr_o(em_addr),
    .rd_ack_i(mem_ack_i && (st_q == S_DATA)), .rd_data_i(mem_rdata_i),
    .tvalid_o(m_tvalid_o), .tready_i(m_tready_i), .tdata_o(m_tdata_o),
    .tlast_o(m_tlast_o), .done_o(emit_done));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st_q <= S_WAIT; k_q <= '0; cur_q <= '0; tail_q <= '0;
      idle_q <= 1'b1; user_q <= '0;
    end else begin
      case (st_q)
        S_WAIT: begin
          if (cur_wr_i) cur_q <= cur_i;
          if (walk_go) begin
            k_q  <= '0;
            st_q <= S_FETCH;
          end
        end
        S_FETCH: if (fetch_take) begin
          if (k_q == IDX_W'(DESC_WORDS-1)) st_q <= S_EVAL;
          else                             k_q  <= k_q + IDX_W'(1);
        end
        S_EVAL: begin
          if (d_done) begin
            idle_q <= 1'b1;
            st_q   <= S_WAIT;
          end else begin
            if (d_sof) user_q <= w_app;
            st_q <= S_WB;
          end
        end
        S_WB: if (wb_take) st_q <= (d_len != '0) ? S_DATA : S_NEXT;
        S_DATA: if (emit_done) st_q <= S_NEXT;
        S_NEXT: begin
          cur_q <= ADDR_W'(w_next);
          if (at_tail) idle_q <= 1'b1;
          st_q <= S_WAIT;
        end
        default: st_q <= S_WAIT;
      endcase
      if (kick_i) begin
        tail_q <= tail_i;
        idle_q <= 1'b0;
      end
    end
  end

  // memory port: walker owns fetch and write-back, emitter owns buffer reads
  always_comb begin
    mem_req_o   = em_req;
    mem_we_o    = 1'b0;
    mem_addr_o  = em_addr;
    mem_wdata_o = done_status(d_len);
    if (st_q == S_FETCH) begin
      mem_req_o  = 1'b1;
      mem_addr_o = cur_q + ADDR_W'({k_q, 2'b00});
    end else if (st_q == S_WB) begin
      mem_req_o  = 1'b1;
      mem_we_o   = 1'b1;
      mem_addr_o = cur_q + ADDR_W'(SLOT_STAT*4);
    end
  end

  assign idle_o       = idle_q;
  assign cur_o        = cur_q;
  assign frame_done_o = (st_q == S_NEXT) && d_eof;
  assign m_tuser_o    = user_q;
endmodule

// File: rtl/sgw_tx_walker_chk.sv
module sgw_tx_walker_chk #(
  parameter int ADDR_W = 32
) (
  input logic              clk,
  input logic              rst_n,
  input logic              kick_i,
  input logic              idle_o,
  input logic              frame_done_o,
  input logic              m_tvalid_o,
  input logic              m_tready_i,
  input logic [7:0]        m_tdata_o,
  input logic              m_tlast_o,
  input logic              mem_req_o,
  input logic              mem_we_o,
  input logic              mem_ack_i,
  input logic [ADDR_W-1:0] mem_addr_o,
  input logic [31:0]       mem_wdata_o,
  input logic              at_tail,
  input logic              hit_done_desc
);
  a_r11_beat_held: assert property (@(posedge clk) disable iff (!rst_n)
    m_tvalid_o && !m_tready_i |=> m_tvalid_o && $stable(m_tdata_o) && $stable(m_tlast_o));

  a_r12_req_held: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req_o && !mem_ack_i |=> mem_req_o && $stable(mem_addr_o) && $stable(mem_we_o));

  a_r7_wb_complete_bit: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req_o && mem_we_o |-> mem_wdata_o[31]);

  a_r10_done_follows_last: assert property (@(posedge clk) disable iff (!rst_n)
    m_tvalid_o && m_tready_i && m_tlast_o |=> ##1 frame_done_o);

  a_r2_idle_no_stream: assert property (@(posedge clk) disable iff (!rst_n)
    idle_o |-> !m_tvalid_o);

  a_r9_tail_stops: assert property (@(posedge clk) disable iff (!rst_n)
    at_tail && !kick_i |=> idle_o && !mem_req_o);

  a_r8_done_desc_stops: assert property (@(posedge clk) disable iff (!rst_n)
    hit_done_desc && !kick_i |=> idle_o && !mem_req_o);
endmodule

bind sgw_tx_walker sgw_tx_walker_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .kick_i(kick_i), .idle_o(idle_o),
  .frame_done_o(frame_done_o), .m_tvalid_o(m_tvalid_o), .m_tready_i(m_tready_i),
  .m_tdata_o(m_tdata_o), .m_tlast_o(m_tlast_o), .mem_req_o(mem_req_o),
  .mem_we_o(mem_we_o), .mem_ack_i(mem_ack_i), .mem_addr_o(mem_addr_o),
  .mem_wdata_o(mem_wdata_o), .at_tail(at_tail), .hit_done_desc(hit_done_desc));

// File: tb/sim_sgw_tx_walker.sv
`timescale 1ns/1ps
module sim_sgw_tx_walker;
  logic clk = 1'b0, rst_n = 1'b0;
  logic run_i = 1'b0, kick_i = 1'b0, cur_wr_i = 1'b0;
  logic [31:0] tail_i = '0, cur_i = '0;
  logic idle_o, frame_done_o, mem_req_o, mem_we_o, mem_ack_i = 1'b0;
  logic [31:0] cur_o, mem_addr_o, mem_wdata_o, mem_rdata_i = '0;
  logic m_tvalid_o, m_tready_i = 1'b0, m_tlast_o;
  logic [7:0] m_tdata_o;
  logic [191:0] m_tuser_o;

  always #2 clk = ~clk;

  sgw_tx_walker u0 (.*);

  int tests = 0, fails = 0, frames = 0;
  int rdy_mode = 0;
  bit stall_en = 1'b0;
  logic [15:0] lfsr = 16'hACE1;
  logic [31:0] mem [0:1023];
  logic [7:0]   q_data[$];
  logic         q_last[$];
  logic [191:0] q_user[$];

  task automatic chk(input bit ok, input string tag, input logic [191:0] act, input logic [191:0] exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
    end
  endtask

  function automatic logic [7:0] buf_byte(input int a);
    return 8'(a) ^ 8'h5A;
  endfunction

  function automatic logic [191:0] user_of(input int seed);
    logic [191:0] u;
    for (int j = 0; j < 6; j++) u[32*j +: 32] = 32'(seed * 16 + j);
    return u;
  endfunction

  // memory model: one-cycle ack, optional random stalls (R12 stimulus)
  always @(posedge clk) begin
    lfsr <= {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
    if (mem_req_o && !mem_ack_i && (!stall_en || lfsr[0])) begin
      mem_ack_i <= 1'b1;
      if (mem_we_o) mem[mem_addr_o[11:2]] <= mem_wdata_o;
      else          mem_rdata_i <= mem[mem_addr_o[11:2]];
    end else begin
      mem_ack_i <= 1'b0;
    end
  end

  // stream sink and scoreboard
  always @(negedge clk) begin
    case (rdy_mode)
      0: m_tready_i = 1'b1;
      1: m_tready_i = ~m_tready_i;
      default: m_tready_i = lfsr[3];
    endcase
    #1;
    if (frame_done_o) frames++;
    if (rst_n && m_tvalid_o && m_tready_i) begin
      if (q_data.size() == 0) chk(1'b0, "R4 unexpected byte", 192'(m_tdata_o), 0);
      else begin
        logic [7:0] ed; logic el; logic [191:0] eu;
        ed = q_data.pop_front(); el = q_last.pop_front(); eu = q_user.pop_front();
        chk(m_tdata_o == ed, "R4 byte value/order", 192'(m_tdata_o), 192'(ed));
        chk(m_tlast_o == el, "R5 tlast placement", 192'(m_tlast_o), 192'(el));
        chk(m_tuser_o == eu, "R6 sideband", m_tuser_o, eu);
      end
    end
  end

  task automatic put_desc(input int da, input int nxt, input int ba, input int len,
                          input bit sof, input bit eof, input bit done, input int seed);
    mem[da/4 + 0] = 32'(nxt); mem[da/4 + 1] = 0;
    mem[da/4 + 2] = 32'(ba);  mem[da/4 + 3] = 0;
    mem[da/4 + 4] = 0;        mem[da/4 + 5] = 0;
    mem[da/4 + 6] = 32'(len) | (32'(eof) << 26) | (32'(sof) << 27);
    mem[da/4 + 7] = done ? 32'h8000_0000 : 32'h0;
    for (int j = 0; j < 6; j++) mem[da/4 + 8 + j] = 32'(seed * 16 + j);
  endtask

  task automatic expect_bytes(input int ba, input int len, input bit eof, input int seed);
    for (int i = 0; i < len; i++) begin
      q_data.push_back(buf_byte(ba + i));
      q_last.push_back(eof && (i == len - 1));
      q_user.push_back(user_of(seed));
    end
  endtask

  task automatic start(input int cur, input int tail);
    @(negedge clk); cur_wr_i = 1'b1; cur_i = 32'(cur);
    @(negedge clk); cur_wr_i = 1'b0; kick_i = 1'b1; tail_i = 32'(tail);
    @(negedge clk); kick_i = 1'b0;
  endtask

  task automatic wait_idle(input string tag);
    int n = 0;
    while (!idle_o && n < 4000) begin @(negedge clk); n++; end
    #2;
    chk(idle_o == 1'b1, {tag, " R9 walk reaches idle"}, 192'(idle_o), 1);
    chk(q_data.size() == 0, {tag, " R4 all bytes delivered"}, 192'(q_data.size()), 0);
  endtask

  task automatic summary;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL watchdog act=running exp=finished");
    summary();
  end

  initial begin
    int f0;
    for (int i = 0; i < 1024; i++)
      for (int b = 0; b < 4; b++) mem[i][8*b +: 8] = buf_byte(4*i + b);
    repeat (4) @(negedge clk);
    // R1: reset state
    chk(idle_o == 1'b1 && mem_req_o == 1'b0 && m_tvalid_o == 1'b0 && cur_o == 0,
        "R1 reset state", {idle_o, mem_req_o, m_tvalid_o, cur_o}, {1'b1, 1'b0, 1'b0, 32'h0});
    rst_n = 1'b1; run_i = 1'b1;

    // single-buffer frame (R3 R5 R7 R9 R10)
    put_desc(32'h000, 32'h040, 32'h200, 5, 1, 1, 0, 1);
    expect_bytes(32'h200, 5, 1, 1);
    f0 = frames;
    start(32'h000, 32'h000); wait_idle("A");
    chk(mem[7] == 32'h8000_0005, "R7 status written", 192'(mem[7]), 192'(32'h8000_0005));
    chk(cur_o == 32'h040, "R9 pointer advanced", 192'(cur_o), 192'(32'h040));
    chk(frames == f0 + 1, "R10 one completion", 192'(frames - f0), 1);

    // frame over three buffers, alternating ready, memory stalls (R6 R11 R12)
    rdy_mode = 1; stall_en = 1'b1;
    put_desc(32'h040, 32'h080, 32'h220, 3, 1, 0, 0, 2);
    put_desc(32'h080, 32'h0C0, 32'h240, 4, 0, 0, 0, 3);
    put_desc(32'h0C0, 32'h100, 32'h260, 6, 0, 1, 0, 4);
    expect_bytes(32'h220, 3, 0, 2); expect_bytes(32'h240, 4, 0, 2); expect_bytes(32'h260, 6, 1, 2);
    f0 = frames;
    start(32'h040, 32'h0C0); wait_idle("B");
    chk(mem[32'h080/4 + 7] == 32'h8000_0004, "R7 middle status", 192'(mem[32'h080/4 + 7]), 192'(32'h8000_0004));
    chk(cur_o == 32'h100, "R9 pointer after chain", 192'(cur_o), 192'(32'h100));
    chk(frames == f0 + 1, "R10 one completion per frame", 192'(frames - f0), 1);

    // two frames back to back, random ready (R5 R10 R11)
    rdy_mode = 2;
    put_desc(32'h100, 32'h140, 32'h280, 7, 1, 1, 0, 5);
    put_desc(32'h140, 32'h180, 32'h2A0, 2, 1, 1, 0, 6);
    expect_bytes(32'h280, 7, 1, 5); expect_bytes(32'h2A0, 2, 1, 6);
    f0 = frames;
    start(32'h100, 32'h140); wait_idle("C");
    chk(frames == f0 + 2, "R10 two completions", 192'(frames - f0), 2);

    // already-complete descriptor stops the walk (R8)
    put_desc(32'h180, 32'h1C0, 32'h2C0, 4, 1, 1, 0, 7);
    put_desc(32'h1C0, 32'h000, 32'h2E0, 9, 1, 1, 1, 8);
    expect_bytes(32'h2C0, 4, 1, 7);
    start(32'h180, 32'h1C0); wait_idle("D");
    chk(cur_o == 32'h1C0, "R8 pointer stays on complete descriptor", 192'(cur_o), 192'(32'h1C0));
    chk(mem[32'h1C0/4 + 7] == 32'h8000_0000, "R8 no write-back", 192'(mem[32'h1C0/4 + 7]), 192'(32'h8000_0000));

    // run low holds off the walk (R2)
    rdy_mode = 0; run_i = 1'b0;
    put_desc(32'h000, 32'h040, 32'h200, 8, 1, 1, 0, 9);
    expect_bytes(32'h200, 8, 1, 9);
    start(32'h000, 32'h000);
    begin
      bit seen = 1'b0;
      for (int c = 0; c < 30; c++) begin @(negedge clk); #1; seen |= mem_req_o; end
      chk(!seen && !idle_o, "R2 no request while run low", {seen, idle_o}, 0);
    end
    run_i = 1'b1; wait_idle("E");

    // length sweep across lane and word boundaries (R3 R4 R5 R11)
    for (int len = 1; len <= 9; len++) begin
      rdy_mode = len % 3; stall_en = len[0];
      put_desc(32'h000, 32'h040, 32'h300, len, 1, 1, 0, len + 10);
      expect_bytes(32'h300, len, 1, len + 10);
      start(32'h000, 32'h000); wait_idle("R3 sweep");
      chk(mem[7] == (32'h8000_0000 | 32'(len)), "R7 sweep status", 192'(mem[7]), 192'(32'h8000_0000 | 32'(len)));
    end
    summary();
  end
endmodule